// File: doc/BRIEF.md
# Precise Trap Commit Controller

This block tracks exception state for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each stage can flag one fault for the instruction it currently holds. The fault is not acted on when it is raised. The block records it in a per-instruction tag that moves down the pipeline with the instruction's PC.

All decisions are made at one commit point, the memory-to-writeback boundary. An instruction that reaches that point with no fault and no pending interrupt is released to writeback. Otherwise the block takes a trap, and taking a trap does the following:
- suppresses writeback of that instruction;
- latches a cause code and the exception PC;
- turns every younger instruction into a bubble, discarding its fault tag;
- redirects fetch to a fixed handler address.

An external interrupt is injected at the same point and wins over any synchronous fault. The datapath itself is outside the block. It only supplies the per-stage fault strobes and the fetch-side instruction stream. The pipeline advances one stage every cycle.

Top module: `precise_trap_ctrl`

## Requirements
- R1: Fault sources map to cause codes: fetch address fault = 1, illegal opcode in decode = 2, arithmetic overflow in execute = 3, data address fault in memory = 4. A fault is reported only when the faulting instruction reaches commit. That happens in the cycle whose edge is the fourth after the instruction was presented at fetch, with `trap_o` high and the code on `cause_o`.
- R2: A fault-free instruction presented at fetch in cycle t raises `wb_valid_o` with its PC on `wb_pc_o` after the fourth following clock edge. Instructions retire in program order.
- R3: Within one instruction, the earliest stage's cause is kept. A later stage's fault on an instruction that already carries a cause is ignored.
- R4: When an older instruction faults, its cause is taken even if a younger instruction raised a fault earlier in time. The younger one never traps.
- R5: A high `ext_irq_i` while a valid instruction sits at commit takes a trap with cause 8 and that instruction's PC as the exception PC, overriding any fault it carries. While no valid instruction is at commit, the interrupt waits.
- R6: On a trap, `trap_o` is high for exactly one cycle, with `redirect_pc_o` equal to the handler address. `wb_valid_o` stays low for the trapping instruction.
- R7: A trap turns the decode, execute and memory stages into bubbles and drops their fault tags. The fetch inputs presented in the decision cycle and in the following cycle are discarded. The first instruction accepted afterwards retires normally.
- R8: `cause_o` and `epc_o` reset to 0. They keep their values until the next trap, regardless of later retirements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | An instruction is presented at fetch |
| fetch_pc_i | input | PC_W | PC of the fetched instruction |
| fetch_fault_i | input | 1 | Fetch address fault for that instruction |
| dec_illegal_i | input | 1 | Illegal opcode for the instruction in decode |
| exe_ovf_i | input | 1 | Overflow for the instruction in execute |
| mem_fault_i | input | 1 | Data address fault for the instruction in memory |
| ext_irq_i | input | 1 | External interrupt request (level) |
| wb_valid_o | output | 1 | Instruction released to writeback |
| wb_pc_o | output | PC_W | PC of the released instruction |
| trap_o | output | 1 | One-cycle trap / flush strobe |
| redirect_pc_o | output | PC_W | Handler address while trap_o is high |
| cause_o | output | 4 | Latched cause of the last trap |
| epc_o | output | PC_W | Latched PC of the last trapping instruction |

## Verification
The bench builds the block with a 16-bit PC and a handler address of 0x0400. This keeps PCs and expected values short. It also makes a stale or defaulted redirect address stand out against the test PCs. Instruction streams are driven with faults lined up against the stage each instruction occupies in a given cycle. This exercises same-instruction collisions, older-versus-younger races, interrupts against faulting and empty commit slots, and the two wrong-path fetch slots after a trap.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE       = 4'd0,
    CZ_FETCH_ADDR = 4'd1,
    CZ_ILLEGAL    = 4'd2,
    CZ_OVERFLOW   = 4'd3,
    CZ_DATA_ADDR  = 4'd4,
    CZ_INTERRUPT  = 4'd8
  } cause_e;

  // Tag stored alongside every in-flight instruction
  function automatic cause_e merge_cause(input logic has_exc, input cause_e cur,
                                         input logic raise, input cause_e code);
    if (has_exc) return cur;
    if (raise)   return code;
    return CZ_NONE;
  endfunction
endpackage

// File: rtl/exc_stage_slot.sv
module exc_stage_slot
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kill_i,
  input  logic            in_vld_i,
  input  logic            in_exc_i,
  input  cause_e          in_cause_i,
  input  logic [PC_W-1:0] in_pc_i,
  input  logic            raise_i,
  input  cause_e          raise_code_i,
  output logic            vld_o,
  output logic            exc_o,
  output cause_e          cause_o,
  output logic [PC_W-1:0] pc_o
);
  logic   nxt_exc;
  cause_e nxt_cause;

  always_comb begin
    nxt_exc   = in_vld_i && (in_exc_i || raise_i);
    nxt_cause = in_vld_i ? merge_cause(in_exc_i, in_cause_i, raise_i, raise_code_i) : CZ_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      vld_o   <= 1'b0;
      exc_o   <= 1'b0;
      cause_o <= CZ_NONE;
      pc_o    <= '0;
    end else begin
      vld_o   <= in_vld_i;
      exc_o   <= nxt_exc;
      cause_o <= nxt_cause;
      pc_o    <= in_pc_i;
    end
  end

  // R3: a cause already attached to the instruction survives the stage
  a_r3_keep_first: assert property (@(posedge clk) disable iff (rst)
    (in_vld_i && in_exc_i && !kill_i) |=> (exc_o && cause_o == $past(in_cause_i)));

  // R7: a killed slot holds a bubble with no tag
  a_r7_bubble: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> (!vld_o && !exc_o));
endmodule

// File: rtl/exc_commit_arb.sv
module exc_commit_arb
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            m_vld_i,
  input  logic            m_exc_i,
  input  cause_e          m_cause_i,
  input  logic [PC_W-1:0] m_pc_i,
  input  logic            mem_fault_i,
  input  logic            ext_irq_i,
  output logic            take_o,
  output cause_e          take_cause_o,
  output logic            commit_o,
  output logic [PC_W-1:0] at_pc_o
);
  logic sync_fault;

  always_comb begin
    sync_fault   = m_vld_i && (m_exc_i || mem_fault_i);
    take_o       = m_vld_i && (ext_irq_i || sync_fault);
    commit_o     = m_vld_i && !take_o;
    at_pc_o      = m_pc_i;
    take_cause_o = CZ_NONE;
    if (m_vld_i) begin
      if (ext_irq_i)       take_cause_o = CZ_INTERRUPT;
      else if (m_exc_i)    take_cause_o = m_cause_i;
      else if (mem_fault_i) take_cause_o = CZ_DATA_ADDR;
    end
  end
endmodule

// File: rtl/exc_trap_regs.sv
module exc_trap_regs
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  cause_e          take_cause_i,
  input  logic            commit_i,
  input  logic [PC_W-1:0] at_pc_i,
  output logic            wb_valid_o,
  output logic [PC_W-1:0] wb_pc_o,
  output logic            trap_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output cause_e          cause_o,
  output logic [PC_W-1:0] epc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid_o    <= 1'b0;
      wb_pc_o       <= '0;
      trap_o        <= 1'b0;
      redirect_pc_o <= '0;
      cause_o       <= CZ_NONE;
      epc_o         <= '0;
    end else begin
      wb_valid_o    <= commit_i;
      wb_pc_o       <= commit_i ? at_pc_i : '0;
      trap_o        <= take_i;
      redirect_pc_o <= take_i ? HANDLER_PC : '0;
      if (take_i) begin
        cause_o <= take_cause_i;
        epc_o   <= at_pc_i;
      end
    end
  end

  // R6: a trapping instruction never reaches writeback
  a_r6_no_wb_on_trap: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_o, wb_valid_o}));

  // R8: the latched trap record is stable between traps
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> ($stable(cause_o) && $stable(epc_o)));
endmodule

// File: rtl/precise_trap_ctrl.sv
module precise_trap_ctrl
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            fetch_fault_i,
  input  logic            dec_illegal_i,
  input  logic            exe_ovf_i,
  input  logic            mem_fault_i,
  input  logic            ext_irq_i,
  output logic            wb_valid_o,
  output logic [PC_W-1:0] wb_pc_o,
  output logic            trap_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [3:0]      cause_o,
  output logic [PC_W-1:0] epc_o
);
  // held stages: decode, execute, memory
  localparam int N_HELD = 3;

  logic            ch_vld   [0:N_HELD];
  logic            ch_exc   [0:N_HELD];
  cause_e          ch_cause [0:N_HELD];
  logic [PC_W-1:0] ch_pc    [0:N_HELD];
  logic            st_raise [0:N_HELD-1];
  cause_e          st_code  [0:N_HELD-1];

  logic            take, commit, kill;
  cause_e          take_cause, cause_q;
  logic [PC_W-1:0] at_pc;

  assign ch_vld[0]   = fetch_valid_i;
  assign ch_exc[0]   = 1'b0;
  assign ch_cause[0] = CZ_NONE;
  assign ch_pc[0]    = fetch_pc_i;

  assign st_raise[0] = fetch_fault_i;
  assign st_code[0]  = CZ_FETCH_ADDR;
  assign st_raise[1] = dec_illegal_i;
  assign st_code[1]  = CZ_ILLEGAL;
  assign st_raise[2] = exe_ovf_i;
  assign st_code[2]  = CZ_OVERFLOW;

  // flush on the decision edge and drop the wrong-path fetch one cycle later
  assign kill = take || trap_o;

  for (genvar g = 0; g < N_HELD; g++) begin : g_slot
    exc_stage_slot #(.PC_W(PC_W)) u_slot (
      .clk          (clk),
      .rst          (rst),
      .kill_i       (kill),
      .in_vld_i     (ch_vld[g]),
      .in_exc_i     (ch_exc[g]),
      .in_cause_i   (ch_cause[g]),
      .in_pc_i      (ch_pc[g]),
      .raise_i      (st_raise[g]),
      .raise_code_i (st_code[g]),
      .vld_o        (ch_vld[g+1]),
      .exc_o        (ch_exc[g+1]),
      .cause_o      (ch_cause[g+1]),
      .pc_o         (ch_pc[g+1])
    );
  end

  exc_commit_arb #(.PC_W(PC_W)) u_arb (
    .m_vld_i      (ch_vld[N_HELD]),
    .m_exc_i      (ch_exc[N_HELD]),
    .m_cause_i    (ch_cause[N_HELD]),
    .m_pc_i       (ch_pc[N_HELD]),
    .mem_fault_i  (mem_fault_i),
    .ext_irq_i    (ext_irq_i),
    .take_o       (take),
    .take_cause_o (take_cause),
    .commit_o     (commit),
    .at_pc_o      (at_pc)
  );

  exc_trap_regs #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .take_i        (take),
    .take_cause_i  (take_cause),
    .commit_i      (commit),
    .at_pc_i       (at_pc),
    .wb_valid_o    (wb_valid_o),
    .wb_pc_o       (wb_pc_o),
    .trap_o        (trap_o),
    .redirect_pc_o (redirect_pc_o),
    .cause_o       (cause_q),
    .epc_o         (epc_o)
  );

  assign cause_o = cause_q;

  // R7: the held stages are empty while the trap strobe is out
  a_r7_flushed: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (!ch_vld[1] && !ch_vld[2] && !ch_vld[3]));

  // R5: an interrupt at an occupied commit slot is taken with its own code
  a_r5_irq_wins: assert property (@(posedge clk) disable iff (rst)
    (ext_irq_i && ch_vld[N_HELD]) |=> (trap_o && cause_o == 4'd8));

  // R6: the trap strobe lasts one cycle
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (rst)
    trap_o |=> !trap_o);
endmodule

// File: tb/precise_trap_ctrl_tb.sv
module precise_trap_ctrl_tb;
  localparam int              PC_W = 16;
  localparam logic [PC_W-1:0] HPC  = 16'h0400;
  localparam int              NS   = 16;

  logic clk = 1'b0;
  logic rst;
  logic fetch_valid, fetch_fault, dec_ill, exe_ovf, mem_flt, irq;
  logic [PC_W-1:0] fetch_pc;
  logic wb_valid, trap;
  logic [PC_W-1:0] wb_pc, redir, epc;
  logic [3:0] cause;

  always #2.5 clk = ~clk;

  precise_trap_ctrl #(.PC_W(PC_W), .HANDLER_PC(HPC)) u_dut (
    .clk(clk), .rst(rst), .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc),
    .fetch_fault_i(fetch_fault), .dec_illegal_i(dec_ill), .exe_ovf_i(exe_ovf),
    .mem_fault_i(mem_flt), .ext_irq_i(irq), .wb_valid_o(wb_valid), .wb_pc_o(wb_pc),
    .trap_o(trap), .redirect_pc_o(redir), .cause_o(cause), .epc_o(epc)
  );

  int vectors = 0;
  int miscompares = 0;

  logic            s_vld [NS];
  logic [PC_W-1:0] s_pc  [NS];
  logic            s_ff [NS], s_il [NS], s_ov [NS], s_df [NS], s_irq [NS];
  logic            l_wb [NS], l_trap [NS];
  logic [PC_W-1:0] l_wbpc [NS], l_epc [NS], l_redir [NS];
  logic [3:0]      l_cause [NS];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fetch_valid = 0; fetch_pc = '0; fetch_fault = 0;
    dec_ill = 0; exe_ovf = 0; mem_flt = 0; irq = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic clear_slots();
    for (int i = 0; i < NS; i++) begin
      s_vld[i] = 0; s_pc[i] = 16'h0100 + 16'(i * 4);
      s_ff[i] = 0; s_il[i] = 0; s_ov[i] = 0; s_df[i] = 0; s_irq[i] = 0;
    end
  endtask

  // stage k fault strobe applies to the instruction fetched k cycles earlier
  task automatic run(input int n);
    for (int t = 0; t < n; t++) begin
      fetch_valid = s_vld[t]; fetch_pc = s_pc[t]; fetch_fault = s_ff[t];
      dec_ill = (t >= 1) ? s_il[t-1] : 1'b0;
      exe_ovf = (t >= 2) ? s_ov[t-2] : 1'b0;
      mem_flt = (t >= 3) ? s_df[t-3] : 1'b0;
      irq     = s_irq[t];
      @(posedge clk);
      @(negedge clk);
      l_wb[t] = wb_valid; l_wbpc[t] = wb_pc; l_trap[t] = trap;
      l_cause[t] = cause; l_epc[t] = epc; l_redir[t] = redir;
    end
    idle_inputs();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 reset cause", cause, 0);
    chk("R8 reset epc", epc, 0);
    chk("R6 reset trap", trap, 0);
    chk("R2 reset wb", wb_valid, 0);
  endtask

  task automatic t_clean_stream();
    do_reset(); clear_slots();
    for (int i = 0; i < 3; i++) s_vld[i] = 1;
    run(8);
    chk("R2 no early wb", l_wb[2], 0);
    for (int i = 0; i < 3; i++) begin
      chk("R2 wb valid", l_wb[i+3], 1);
      chk("R2 wb pc order", l_wbpc[i+3], s_pc[i]);
      chk("R1 no trap clean", l_trap[i+3], 0);
    end
  endtask

  task automatic t_illegal_flush();
    do_reset(); clear_slots();
    for (int i = 0; i < 6; i++) s_vld[i] = 1;
    s_il[0] = 1;
    s_ov[1] = 1;   // younger fault, must vanish with the flush
    run(10);
    chk("R1 not before commit", l_trap[2], 0);
    chk("R1 trap at commit", l_trap[3], 1);
    chk("R1 illegal code", l_cause[3], 2);
    chk("R6 epc", l_epc[3], s_pc[0]);
    chk("R6 redirect", l_redir[3], HPC);
    chk("R6 no wb on trap", l_wb[3], 0);
    chk("R6 single pulse", l_trap[4], 0);
    for (int t = 4; t < 8; t++) begin
      chk("R7 killed no wb", l_wb[t], 0);
      chk("R7 killed no trap", l_trap[t], 0);
    end
    chk("R7 first accepted retires", l_wb[8], 1);
    chk("R7 first accepted pc", l_wbpc[8], s_pc[5]);
    chk("R8 cause held", l_cause[8], 2);
    chk("R8 epc held", l_epc[8], s_pc[0]);
  endtask

  task automatic t_older_wins();
    do_reset(); clear_slots();
    for (int i = 0; i < 3; i++) s_vld[i] = 1;
    s_ov[0] = 1;   // older, raised at t=2
    s_ff[1] = 1;   // younger, raised earlier at t=1
    run(8);
    chk("R4 trap older", l_trap[3], 1);
    chk("R4 older cause", l_cause[3], 3);
    chk("R4 older epc", l_epc[3], s_pc[0]);
    chk("R4 younger never traps", l_trap[4], 0);
  endtask

  task automatic t_same_instr();
    do_reset(); clear_slots();
    s_vld[0] = 1; s_ff[0] = 1; s_df[0] = 1;
    s_vld[6] = 1; s_il[6] = 1; s_ov[6] = 1;
    run(12);
    chk("R3 fetch kept over data", l_cause[3], 1);
    chk("R3 trap", l_trap[3], 1);
    chk("R3 illegal kept over ovf", l_cause[9], 2);
    chk("R3 epc", l_epc[9], s_pc[6]);
  endtask

  task automatic t_data_fault();
    do_reset(); clear_slots();
    s_vld[0] = 1; s_df[0] = 1;
    run(6);
    chk("R1 data fault code", l_cause[3], 4);
    chk("R1 data fault trap", l_trap[3], 1);
  endtask

  task automatic t_irq_over_fault();
    do_reset(); clear_slots();
    s_vld[0] = 1; s_vld[1] = 1; s_il[0] = 1; s_irq[3] = 1;
    run(8);
    chk("R5 irq trap", l_trap[3], 1);
    chk("R5 irq code", l_cause[3], 8);
    chk("R5 irq epc", l_epc[3], s_pc[0]);
    chk("R7 younger killed", l_wb[4], 0);
  endtask

  task automatic t_irq_waits();
    do_reset(); clear_slots();
    s_vld[4] = 1;
    for (int t = 0; t < 8; t++) s_irq[t] = 1;
    run(10);
    for (int t = 0; t < 7; t++) chk("R5 irq waits", l_trap[t], 0);
    chk("R5 irq taken at commit", l_trap[7], 1);
    chk("R5 irq code late", l_cause[7], 8);
    chk("R5 irq epc late", l_epc[7], s_pc[4]);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1;
    idle_inputs();
    t_reset();
    t_clean_stream();
    t_illegal_flush();
    t_older_wins();
    t_same_instr();
    t_data_fault();
    t_irq_over_fault();
    t_irq_waits();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule